// File: doc/BRIEF.md
# Fast link pulse page receiver

This block turns a stream of detected link pulses into 16-bit pages. The analog front end hands it a one-cycle strobe for every pulse it sees, and a separate time-base tick sets the unit of time. The receiver measures how many ticks have passed since the most recent clock pulse. From that measure it sorts each new pulse into a data pulse or the next clock pulse, and it shifts one bit into the page for every clock-to-clock interval.

A burst ends when the line stays quiet for a programmable number of ticks. A burst that carried exactly seventeen clock pulses yields a page. A match stage counts how many consecutive pages came out identical, and it raises a one-cycle valid strobe once that count reaches three. A malformed burst raises a one-cycle error strobe, discards its partial page and clears the match history. The receiver then ignores the line until it has been quiet for a full gap.

Top module: `flp_page_rx`

## Requirements
- R1: The measured interval is the number of ticks counted since the last clock pulse, including a tick in the current cycle. When the receiver is idle, a pulse opens a burst and counts as its first clock pulse. Within a burst, a pulse with an interval of 110 to 140 ticks is a clock pulse, and one with an interval of 55 to 70 ticks is a data pulse.
- R2: Each interval between two clock pulses is one bit. The bit is 1 if a data pulse fell inside that interval and 0 if none did. The interval after clock pulse k (k = 1..16) is page bit k-1, so the page is least significant bit first.
- R3: A burst ends once 200 ticks have passed since its last clock pulse. If it held exactly 17 clock pulses, its page appears on page_o. page_o changes only when such a page completes.
- R4: page_valid_o pulses for one cycle when a completed page equals the two pages completed just before it. It pulses again for every further identical page.
- R5: A completed page that differs from the previous one restarts the run at one. It takes two more identical pages before the next valid strobe.
- R6: Within a burst, a pulse whose interval is outside both windows raises err_o for one cycle. The partial page is dropped and page_o keeps its value.
- R7: A burst that times out with fewer than 17 clock pulses raises err_o and produces no page.
- R8: Each of the following raises err_o: an 18th clock pulse, a data pulse after the 17th clock pulse, or a second data pulse within one interval.
- R9: After an error, every pulse is ignored until 200 ticks pass with no pulse at all. A bad burst therefore gives exactly one error strobe.
- R10: An error clears the match run. Three new identical pages are needed before the next valid strobe.
- R11: After reset, page_o is 0 and both strobes are low.
- R12: Time advances only on cycles where tick_i is high. Stretching the tick period leaves the decoded pages unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time-base tick, one unit of interval measure |
| pulse_i | input | 1 | One-cycle strobe for each detected link pulse |
| page_o | output | 16 | Most recently completed page |
| page_valid_o | output | 1 | One-cycle strobe: page_o has been seen three times in a row |
| err_o | output | 1 | One-cycle strobe: malformed burst discarded |

## Verification
The hardest cases to reach are pulses that sit exactly on, or one tick outside, a window edge. A bench that drives pulses by cycle count would blur these, so the stimulus counts delivered ticks and fires each pulse on the exact tick that gives the intended interval. A sweep pairs every page pattern with the extreme data and clock spacings (55, 70, 110, 140). Error bursts probe 54, 71, 109 and 141 ticks, short and long bursts, doubled data pulses and trailing data pulses. These error bursts are woven between good pages so the reset of the match run shows up. A final pass stretches the tick to every second cycle.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_BURST   = 2'd1,
        RX_RECOVER = 2'd2
    } rx_state_e;

    function automatic logic in_win(input int unsigned v, input int unsigned lo,
                                    input int unsigned hi);
        return (v >= lo) && (v <= hi);
    endfunction

endpackage

// File: rtl/flp_gap_timer.sv
module flp_gap_timer #(
    parameter int unsigned GAP_TICKS = 200,
    parameter int unsigned TW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          clr_i,
    output logic [TW-1:0] meas_o
);
    localparam logic [TW-1:0] SAT = TW'(GAP_TICKS);

    logic [TW-1:0] elapsed_d, elapsed_q;

    always_comb begin
        meas_o    = (tick_i && elapsed_q != SAT) ? elapsed_q + TW'(1) : elapsed_q;
        elapsed_d = clr_i ? '0 : meas_o;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) elapsed_q <= '0;
        else        elapsed_q <= elapsed_d;
    end

    assert_meas_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed_q == SAT && !clr_i) |=> elapsed_q == SAT);

endmodule

// File: rtl/flp_slot_decoder.sv
module flp_slot_decoder
    import flp_pkg::*;
#(
    parameter int unsigned PAGE_BITS = 16,
    parameter int unsigned DATA_MIN  = 55,
    parameter int unsigned DATA_MAX  = 70,
    parameter int unsigned CLK_MIN   = 110,
    parameter int unsigned CLK_MAX   = 140,
    parameter int unsigned GAP_TICKS = 200,
    parameter int unsigned TW        = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pulse_i,
    input  logic [TW-1:0]        meas_i,
    output logic                 clr_o,
    output logic                 done_o,
    output logic                 err_o,
    output logic [PAGE_BITS-1:0] page_o
);
    localparam int unsigned   CLOCKS   = PAGE_BITS + 1;
    localparam int unsigned   CW       = $clog2(CLOCKS + 1);
    localparam logic [CW-1:0] NCL_FULL = CW'(CLOCKS);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        ncl;
        logic                 dseen;
        logic [PAGE_BITS-1:0] bits;
        logic                 done;
        logic                 err;
        logic [PAGE_BITS-1:0] page;
    } dec_t;

    dec_t d, q;
    logic is_clk, is_dat, timed_out;

    always_comb begin
        is_clk    = in_win(32'(meas_i), CLK_MIN, CLK_MAX);
        is_dat    = in_win(32'(meas_i), DATA_MIN, DATA_MAX);
        timed_out = 32'(meas_i) >= GAP_TICKS;
        d         = q;
        d.done    = 1'b0;
        d.err     = 1'b0;
        clr_o     = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (pulse_i) begin
                    d.st    = RX_BURST;
                    d.ncl   = CW'(1);
                    d.dseen = 1'b0;
                    d.bits  = '0;
                    clr_o   = 1'b1;
                end
            end
            RX_BURST: begin
                if (pulse_i) begin
                    if (is_clk && q.ncl != NCL_FULL) begin
                        d.bits  = {q.dseen, q.bits[PAGE_BITS-1:1]};
                        d.ncl   = q.ncl + CW'(1);
                        d.dseen = 1'b0;
                        clr_o   = 1'b1;
                    end else if (is_dat && !q.dseen && q.ncl != NCL_FULL) begin
                        d.dseen = 1'b1;
                    end else begin
                        d.err = 1'b1;
                        d.st  = RX_RECOVER;
                        clr_o = 1'b1;
                    end
                end else if (timed_out) begin
                    if (q.ncl == NCL_FULL) begin
                        d.done = 1'b1;
                        d.page = q.bits;
                    end else begin
                        d.err = 1'b1;
                    end
                    d.st = RX_IDLE;
                end
            end
            RX_RECOVER: begin
                if (pulse_i)        clr_o = 1'b1;
                else if (timed_out) d.st  = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign done_o = q.done;
    assign err_o  = q.err;
    assign page_o = q.page;

    assert_burst_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_BURST) |-> (q.ncl >= CW'(1) && q.ncl <= NCL_FULL));

    assert_done_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> $past(q.st == RX_BURST && q.ncl == NCL_FULL));

    assert_done_err_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done && q.err));

    assert_recover_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_RECOVER) |=> !q.err);

endmodule

// File: rtl/flp_match_filter.sv
module flp_match_filter #(
    parameter int unsigned PAGE_BITS  = 16,
    parameter int unsigned MATCH_NEED = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 done_i,
    input  logic                 err_i,
    input  logic [PAGE_BITS-1:0] page_i,
    output logic [PAGE_BITS-1:0] page_o,
    output logic                 valid_o
);
    localparam int unsigned   RW       = $clog2(MATCH_NEED + 1);
    localparam logic [RW-1:0] RUN_FULL = RW'(MATCH_NEED);

    typedef struct packed {
        logic [PAGE_BITS-1:0] last;
        logic [RW-1:0]        run;
        logic                 valid;
    } mf_t;

    mf_t d, q;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        if (err_i) begin
            d.run = '0;
        end else if (done_i) begin
            if (q.run != '0 && page_i == q.last) begin
                if (q.run != RUN_FULL) d.run = q.run + RW'(1);
            end else begin
                d.run = RW'(1);
            end
            d.last  = page_i;
            d.valid = (d.run == RUN_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign page_o  = q.last;
    assign valid_o = q.valid;

    assert_valid_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> $past(done_i));

    assert_valid_full_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |-> q.run == RUN_FULL);

    assert_page_moves_on_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.last) |-> $past(done_i));

endmodule

// File: rtl/flp_page_rx.sv
module flp_page_rx #(
    parameter int unsigned PAGE_BITS  = 16,
    parameter int unsigned DATA_MIN   = 55,
    parameter int unsigned DATA_MAX   = 70,
    parameter int unsigned CLK_MIN    = 110,
    parameter int unsigned CLK_MAX    = 140,
    parameter int unsigned GAP_TICKS  = 200,
    parameter int unsigned MATCH_NEED = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick_i,
    input  logic                 pulse_i,
    output logic [PAGE_BITS-1:0] page_o,
    output logic                 page_valid_o,
    output logic                 err_o
);
    localparam int unsigned TW = $clog2(GAP_TICKS + 1);

    logic [TW-1:0]        meas;
    logic                 clr;
    logic                 dec_done;
    logic [PAGE_BITS-1:0] dec_page;

    flp_gap_timer #(
        .GAP_TICKS(GAP_TICKS),
        .TW       (TW)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_i(tick_i),
        .clr_i (clr),
        .meas_o(meas)
    );

    flp_slot_decoder #(
        .PAGE_BITS(PAGE_BITS),
        .DATA_MIN (DATA_MIN),
        .DATA_MAX (DATA_MAX),
        .CLK_MIN  (CLK_MIN),
        .CLK_MAX  (CLK_MAX),
        .GAP_TICKS(GAP_TICKS),
        .TW       (TW)
    ) u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .pulse_i(pulse_i),
        .meas_i (meas),
        .clr_o  (clr),
        .done_o (dec_done),
        .err_o  (err_o),
        .page_o (dec_page)
    );

    flp_match_filter #(
        .PAGE_BITS (PAGE_BITS),
        .MATCH_NEED(MATCH_NEED)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .done_i (dec_done),
        .err_i  (err_o),
        .page_i (dec_page),
        .page_o (page_o),
        .valid_o(page_valid_o)
    );

    assert_err_blocks_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !page_valid_o);

endmodule

// File: tb/tb_flp_page_rx.sv
module tb_flp_page_rx;
    localparam int GAP = 200;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        pulse = 1'b0;
    logic [15:0] page;
    logic        valid, err;

    int n_checks = 0, n_fail = 0;
    int valid_cnt = 0, err_cnt = 0;
    int div = 1, div_cnt = 0;
    int exp_valid = 0, exp_err = 0, run = 0;
    logic [15:0] last_p = '0;

    always #5 clk = ~clk;

    flp_page_rx dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .pulse_i(pulse),
        .page_o(page), .page_valid_o(valid), .err_o(err)
    );

    always @(negedge clk) begin
        if (valid) valid_cnt++;
        if (err)   err_cnt++;
    end

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic adv(input int n, input bit p);
        int got = 0;
        while (got < n) begin
            @(negedge clk);
            tick = (div_cnt == 0);
            div_cnt = (div_cnt + 1) % div;
            if (tick) got++;
            pulse = (tick && got == n) ? p : 1'b0;
        end
    endtask

    task automatic burst(input logic [15:0] p, input int nclk, input int ds, input int cs);
        adv(1, 1'b1);
        for (int i = 0; i < nclk - 1; i++) begin
            if (i < 16 && p[i]) begin
                adv(ds, 1'b1);
                adv(cs - ds, 1'b1);
            end else begin
                adv(cs, 1'b1);
            end
        end
        adv(GAP + 4, 1'b0);
    endtask

    task automatic good(input logic [15:0] p, input int ds, input int cs, input string req);
        burst(p, 17, ds, cs);
        if (run != 0 && p == last_p) run = (run == 3) ? 3 : run + 1;
        else run = 1;
        last_p = p;
        if (run == 3) exp_valid++;
        check({req, " page"}, int'(page), int'(p));
        check({req, " valid count"}, valid_cnt, exp_valid);
        check({req, " error count"}, err_cnt, exp_err);
    endtask

    task automatic after_bad(input string req);
        exp_err++;
        run = 0;
        check({req, " one error"}, err_cnt, exp_err);
        check({req, " page kept"}, int'(page), int'(last_p));
        check({req, " no valid"}, valid_cnt, exp_valid);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] pats [6] = '{16'h0000, 16'hFFFF, 16'h0001, 16'h8000, 16'hA5C3, 16'h3C96};
        int dsv [6] = '{55, 70, 62, 55, 70, 60};
        int csv [6] = '{110, 140, 125, 140, 110, 131};

        repeat (4) @(negedge clk);
        check("R11 reset page", int'(page), 0);
        check("R11 reset valid", int'(valid), 0);
        check("R11 reset err", int'(err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R2 R3 R4: patterns against window corners, three bursts each
        for (int k = 0; k < 6; k++)
            for (int j = 0; j < 3; j++)
                good(pats[k], dsv[(k + j) % 6], csv[(k + j) % 6], "R2 R4 sweep");

        // R5: a differing page restarts the run
        good(16'h1234, 62, 125, "R5 first");
        good(16'h1234, 62, 125, "R5 second");
        good(16'h4321, 62, 125, "R5 changed");
        good(16'h4321, 62, 125, "R5 changed x2");
        good(16'h4321, 62, 125, "R5 changed x3");

        // R6: one tick outside each window edge
        burst(16'h0001, 17, 54, 125); after_bad("R6 data 54");
        burst(16'h0001, 17, 71, 125); after_bad("R6 data 71");
        burst(16'h0000, 17, 60, 109); after_bad("R6 clock 109");
        burst(16'h0000, 17, 60, 141); after_bad("R6 clock 141");

        // R7: short burst
        burst(16'h00FF, 16, 60, 125); after_bad("R7 sixteen clocks");

        // R8: long burst, doubled data, trailing data
        burst(16'h0000, 18, 60, 125); after_bad("R8 eighteen clocks");
        adv(1, 1'b1); adv(56, 1'b1); adv(9, 1'b1); adv(GAP + 4, 1'b0);
        after_bad("R8 double data");
        adv(1, 1'b1);
        for (int i = 0; i < 16; i++) adv(125, 1'b1);
        adv(60, 1'b1); adv(GAP + 4, 1'b0);
        after_bad("R8 data after last clock R9");

        // R10: error between matching pages clears the run
        good(16'hC0DE, 62, 125, "R10 a");
        good(16'hC0DE, 62, 125, "R10 b");
        burst(16'h0001, 17, 75, 125); after_bad("R10 error");
        good(16'hC0DE, 62, 125, "R10 c");
        good(16'hC0DE, 62, 125, "R10 d");
        good(16'hC0DE, 62, 125, "R10 e");

        // R12: tick every second cycle
        div = 2; div_cnt = 0;
        good(16'h5A0F, 62, 125, "R12 slow a");
        good(16'h5A0F, 55, 140, "R12 slow b");
        good(16'h5A0F, 70, 110, "R12 slow c");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule